// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits between instruction decode and the data memory port of a simple load/store processor. Each cycle it may accept one 32-bit instruction word together with the current program counter and the value of the base register named by the instruction. It works out the byte address that the instruction refers to. It then says what should be done with that address: read memory, write memory, or hand the address itself to the register file as a result.

The base register value comes from an external register-file read port. The block drives that port's index combinationally from the instruction word, so the value arrives in the same cycle. Every other result is registered and appears one clock after the instruction is accepted. A base field of zero means "no base register": the constant alone becomes the address. Two opcodes use the program counter as the base, together with a wider constant. Every access is a full 32-bit word, and within a word the lowest byte address holds the most significant byte. The block only forms word addresses and never reorders bytes.

Top module: `ls_addr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `rd_stb`, `wr_stb`, `addr_only`, `ea` and `dst_idx` are all zero after that edge.
- R2: Opcode 1 (bits 31..27) with valid high and a nonzero base field (bits 21..17) gives, one cycle later, `rd_stb`=1 and `ea` = `rb_val` + the sign-extended 17-bit constant in bits 16..0.
- R3: When the base field is zero for opcodes 1, 3 and 5, `ea` is the sign-extended 17-bit constant alone, and `rb_val` has no effect.
- R4: Opcode 3 gives `wr_stb`=1 one cycle later, with the same address rule as R2. A zero constant gives `ea` = `rb_val`.
- R5: Opcode 5 gives `addr_only`=1 one cycle later, with both strobes low and `ea` formed as in R2 or R3.
- R6: Opcode 2 gives `rd_stb`=1 one cycle later, with `ea` = `pc` + the sign-extended 22-bit constant in bits 21..0.
- R7: Opcode 6 gives `addr_only`=1 one cycle later, with both strobes low and `ea` = `pc` + the sign-extended 22-bit constant.
- R8: Address sums wrap modulo 2^32, and negative constants subtract.
- R9: At most one of `rd_stb`, `wr_stb` and `addr_only` is high at a time. All three are low one cycle after valid is low or the opcode is anything other than 1, 2, 3, 5 or 6, so each one pulses for exactly one cycle per accepted instruction.
- R10: `rb_sel` equals bits 21..17 of `insn` in the same cycle, with no clock delay.
- R11: `dst_idx` equals bits 26..22 of the instruction that was presented at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 32 | Current program counter |
| rb_val | input | 32 | Register-file value for index `rb_sel` |
| rb_sel | output | 5 | Base register index to the register-file read port |
| ea | output | 32 | Effective address, registered |
| rd_stb | output | 1 | One-cycle memory read request |
| wr_stb | output | 1 | One-cycle memory write request |
| addr_only | output | 1 | Write `ea` itself to register `dst_idx` |
| dst_idx | output | 5 | Destination register (loads) or source register (stores) |

## Verification
The block keeps no state across instructions beyond its single output register. A wrong base or constant selection, or a misclassified opcode, therefore shows on `ea` or on the strobes exactly one clock after the offending instruction, and only for that instruction. Because of this, the bench compares every output on every cycle against a behavioural model. It also places a valid-low cycle after each instruction, so that a strobe that stays high too long is caught on the following cycle.

// File: rtl/ls_ea_pkg.sv
package ls_ea_pkg;
  localparam int OPC_BITS = 5;

  localparam logic [OPC_BITS-1:0] OPC_LOAD      = 5'd1;
  localparam logic [OPC_BITS-1:0] OPC_LOAD_REL  = 5'd2;
  localparam logic [OPC_BITS-1:0] OPC_STORE     = 5'd3;
  localparam logic [OPC_BITS-1:0] OPC_ADDR      = 5'd5;
  localparam logic [OPC_BITS-1:0] OPC_ADDR_REL  = 5'd6;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ADDR  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/ls_field_decode.sv
module ls_field_decode
  import ls_ea_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int DISP_W = 17,
  parameter int REL_W  = 22
) (
  input  logic [DATA_W-1:0]   insn,
  input  logic [DATA_W-1:0]   pc,
  input  logic [DATA_W-1:0]   rb_val,
  output logic [OPC_BITS-1:0] opc,
  output logic [REG_W-1:0]    ra_f,
  output logic [REG_W-1:0]    rb_f,
  output acc_kind_e           kind,
  output logic [DATA_W-1:0]   base,
  output logic [DATA_W-1:0]   offset
);
  localparam int RA_TOP = DATA_W - OPC_BITS - 1;
  localparam int RB_TOP = RA_TOP - REG_W;

  logic [DATA_W-1:0] disp_x;
  logic [DATA_W-1:0] rel_x;
  logic [DATA_W-1:0] reg_base;

  assign opc  = insn[DATA_W-1 -: OPC_BITS];
  assign ra_f = insn[RA_TOP -: REG_W];
  assign rb_f = insn[RB_TOP -: REG_W];

  assign disp_x   = {{(DATA_W-DISP_W){insn[DISP_W-1]}}, insn[DISP_W-1:0]};
  assign rel_x    = {{(DATA_W-REL_W){insn[REL_W-1]}}, insn[REL_W-1:0]};
  assign reg_base = (rb_f == '0) ? '0 : rb_val;

  always_comb begin
    kind   = ACC_NONE;
    base   = '0;
    offset = '0;
    case (opc)
      OPC_LOAD:     begin kind = ACC_READ;  base = reg_base; offset = disp_x; end
      OPC_STORE:    begin kind = ACC_WRITE; base = reg_base; offset = disp_x; end
      OPC_ADDR:     begin kind = ACC_ADDR;  base = reg_base; offset = disp_x; end
      OPC_LOAD_REL: begin kind = ACC_READ;  base = pc;       offset = rel_x;  end
      OPC_ADDR_REL: begin kind = ACC_ADDR;  base = pc;       offset = rel_x;  end
      default:      begin kind = ACC_NONE;  base = '0;       offset = '0;     end
    endcase
  end
endmodule

// File: rtl/ls_addr_adder.sv
module ls_addr_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  output logic [DATA_W-1:0] sum
);
  // Carry out is dropped on purpose: addresses wrap modulo 2^DATA_W.
  assign sum = base + offset;
endmodule

// File: rtl/ls_addr_unit.sv
module ls_addr_unit
  import ls_ea_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int DISP_W = 17,
  parameter int REL_W  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [DATA_W-1:0] insn,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rb_val,
  output logic [REG_W-1:0]  rb_sel,
  output logic [DATA_W-1:0] ea,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              addr_only,
  output logic [REG_W-1:0]  dst_idx
);
  logic [OPC_BITS-1:0] opc;
  logic [REG_W-1:0]    ra_f;
  logic [REG_W-1:0]    rb_f;
  acc_kind_e           kind;
  logic [DATA_W-1:0]   base;
  logic [DATA_W-1:0]   offset;
  logic [DATA_W-1:0]   sum;

  ls_field_decode #(
    .DATA_W(DATA_W), .REG_W(REG_W), .DISP_W(DISP_W), .REL_W(REL_W)
  ) u_dec (
    .insn(insn), .pc(pc), .rb_val(rb_val),
    .opc(opc), .ra_f(ra_f), .rb_f(rb_f),
    .kind(kind), .base(base), .offset(offset)
  );

  ls_addr_adder #(.DATA_W(DATA_W)) u_add (
    .base(base), .offset(offset), .sum(sum)
  );

  assign rb_sel = rb_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea        <= '0;
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      addr_only <= 1'b0;
      dst_idx   <= '0;
    end else begin
      ea        <= sum;
      rd_stb    <= insn_valid && (kind == ACC_READ);
      wr_stb    <= insn_valid && (kind == ACC_WRITE);
      addr_only <= insn_valid && (kind == ACC_ADDR);
      dst_idx   <= ra_f;
    end
  end

  assert_one_action_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_stb, wr_stb, addr_only}));

  assert_read_origin_R2: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> ($past(insn_valid) &&
               ($past(opc) == OPC_LOAD || $past(opc) == OPC_LOAD_REL)));

  assert_write_origin_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(insn_valid) && $past(opc) == OPC_STORE));

  assert_addr_origin_R5: assert property (@(posedge clk) disable iff (rst)
    addr_only |-> ($past(insn_valid) &&
                  ($past(opc) == OPC_ADDR || $past(opc) == OPC_ADDR_REL)));

  assert_absolute_R3: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && opc == OPC_LOAD && insn[DATA_W-OPC_BITS-REG_W-1 -: REG_W] == '0)
    |=> ea == $past({{(DATA_W-DISP_W){insn[DISP_W-1]}}, insn[DISP_W-1:0]}));

  assert_pc_relative_R6: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && opc == OPC_LOAD_REL)
    |=> ea == $past(pc) + $past({{(DATA_W-REL_W){insn[REL_W-1]}}, insn[REL_W-1:0]}));
endmodule

// File: tb/sim_ls_addr_unit.sv
`timescale 1ns/1ps
module sim_ls_addr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] pc = '0;
  logic [31:0] rb_val = '0;
  logic [4:0]  rb_sel;
  logic [31:0] ea;
  logic        rd_stb, wr_stb, addr_only;
  logic [4:0]  dst_idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ls_addr_unit u0 (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .pc(pc),
    .rb_val(rb_val), .rb_sel(rb_sel), .ea(ea), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .addr_only(addr_only), .dst_idx(dst_idx)
  );

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int ra, input int rb, input int c);
    mk = {op[4:0], ra[4:0], rb[4:0], c[16:0]};
  endfunction

  function automatic logic [31:0] mkr(input int op, input int ra, input int c);
    mkr = {op[4:0], ra[4:0], c[21:0]};
  endfunction

  // Behavioural model: expected outputs for one accepted instruction.
  task automatic step(input string tag, input logic v, input logic [31:0] w,
                      input logic [31:0] p, input logic [31:0] r);
    int op, rbn;
    longint d17, d22, basev, exp_ea;
    bit er, ew, ea_f, addr_chk;
    op  = int'(w[31:27]);
    rbn = int'(w[21:17]);
    d17 = longint'($signed(w[16:0]));
    d22 = longint'($signed(w[21:0]));
    basev = (rbn == 0) ? 0 : longint'(r);
    er = 0; ew = 0; ea_f = 0; addr_chk = 1;
    case (op)
      1: begin er = 1; exp_ea = (basev + d17) & 64'hFFFF_FFFF; end
      3: begin ew = 1; exp_ea = (basev + d17) & 64'hFFFF_FFFF; end
      5: begin ea_f = 1; exp_ea = (basev + d17) & 64'hFFFF_FFFF; end
      2: begin er = 1; exp_ea = (longint'(p) + d22) & 64'hFFFF_FFFF; end
      6: begin ea_f = 1; exp_ea = (longint'(p) + d22) & 64'hFFFF_FFFF; end
      default: begin addr_chk = 0; exp_ea = 0; end
    endcase
    if (!v) begin er = 0; ew = 0; ea_f = 0; end
    @(negedge clk);
    insn_valid = v; insn = w; pc = p; rb_val = r;
    #1;
    chk({tag, " R10"}, "rb_sel", rb_sel, w[21:17]);
    @(negedge clk);
    chk(tag, "rd_stb", rd_stb, er);
    chk(tag, "wr_stb", wr_stb, ew);
    chk(tag, "addr_only", addr_only, ea_f);
    chk({tag, " R11"}, "dst_idx", dst_idx, w[26:22]);
    if (addr_chk) chk(tag, "ea", ea, exp_ea);
    insn_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R9 pulse"}, "strobes", {rd_stb, wr_stb, addr_only}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rd_stb", rd_stb, 0);
    chk("R1", "wr_stb", wr_stb, 0);
    chk("R1", "addr_only", addr_only, 0);
    chk("R1", "ea", ea, 0);
    chk("R1", "dst_idx", dst_idx, 0);
    rst = 1'b0;
    step("R2 load disp",       1, mk(1, 3, 4, 24),        32'h0, 32'h0000_1000);
    step("R2 load neg disp",   1, mk(1, 9, 7, -8),        32'h0, 32'h0000_0100);
    step("R3 load absolute",   1, mk(1, 1, 0, 32),        32'h0, 32'hDEAD_BEEF);
    step("R3 la absolute",     1, mk(5, 7, 0, -5),        32'h0, 32'h1234_5678);
    step("R4 store disp",      1, mk(3, 4, 9, 100),       32'h0, 32'h0000_2000);
    step("R4 store indirect",  1, mk(3, 4, 9, 0),         32'h0, 32'hCAFE_0010);
    step("R3 store absolute",  1, mk(3, 2, 0, 16'h7FF0), 32'h0, 32'hFFFF_FFFF);
    step("R5 la with base",    1, mk(5, 12, 3, 40),       32'h0, 32'h0000_0500);
    step("R6 ldr negative",    1, mkr(2, 12, -48),        32'h0000_5000, 32'h0);
    step("R6 ldr positive",    1, mkr(2, 8, 22'h1FFFFF),  32'h0001_0000, 32'h0);
    step("R7 lar",             1, mkr(6, 3, 0),           32'h0000_4444, 32'h0);
    step("R7 lar neg",         1, mkr(6, 30, -4),         32'h0000_0002, 32'h0);
    step("R8 wrap up",         1, mk(1, 5, 6, 32),        32'h0, 32'hFFFF_FFF0);
    step("R8 wrap down",       1, mkr(2, 5, -16),         32'h0000_0004, 32'h0);
    step("R9 opcode 0",        1, mk(0, 5, 6, 32),        32'h0, 32'h10);
    step("R9 opcode 4",        1, mk(4, 5, 6, 32),        32'h0, 32'h10);
    step("R9 opcode 7",        1, mk(7, 5, 6, 32),        32'h0, 32'h10);
    step("R9 opcode 31",       1, mk(31, 5, 6, 32),       32'h0, 32'h10);
    step("R9 valid low",       0, mk(1, 5, 6, 32),        32'h0, 32'h10);
    step("R9 valid low st",    0, mk(3, 5, 6, 32),        32'h0, 32'h10);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule